// File: doc/BRIEF.md
# Wait-Mode Wake-Up Sequencer

This block takes a CPU core out of a clock-gated wait state. Software requests wait by pulsing a wait-request input. The block then records, in the same cycle, three settings: whether internal power runs in a low-consumption state during the wait, whether flash is shut down during the wait, and which clock source the CPU should use after it wakes. The CPU clock is then gated off until a peripheral interrupt with a non-zero 3-bit priority level arrives.

On a wake the block runs three phases in a fixed order. The first is power stabilisation, which lasts 100 microsecond ticks and runs only if low consumption was chosen. The second is flash reactivation: one system clock, plus 60 ticks if flash was shut down. The third is clock restart: two cycles of running CPU clock before the ready flag rises. The clock select value and the oscillator and divider fields derived from it take their new value when the clock restart phase begins. Any qualifying interrupt that arrives during the wait or the sequence is held and shown to the CPU when it is ready.

Top module: `wake_seq`

## Requirements
- R1: In wait, a request whose 3-bit level is 000 never starts a wake. A request with any non-zero level starts the sequence on the next clock edge.
- R2: A `wait_set` pulse while ready drops `cpu_ready` and `cpu_clk_en` on the next edge. The same edge captures `lowpwr_cfg`, `flash_stop_cfg` and `clk_src_cfg`. Later changes to those inputs have no effect on this wait.
- R3: With low consumption captured, `lp_mode` is 1 during the wait and the power phase. The power phase ends on the edge that samples its 100th `us_tick`. Without low consumption the phase is skipped and `lp_mode` stays 0.
- R4: The flash phase lasts one cycle in which ticks are ignored. If flash was stopped, 60 further ticks follow. `flash_en` is 0 from wait entry to the end of that phase when flash was stopped, and 1 otherwise.
- R5: `cpu_clk_en` is 1 for exactly two cycles before `cpu_ready` returns to 1.
- R6: The phases run strictly in the order power, flash, clock restart.
- R7: `clk_sel` keeps its old value during the wait. It takes the captured field when clock restart begins. `osc_lo_sel` equals bit 2 and `div_sel` equals bits 1:0 of `clk_sel`.
- R8: `wait_set` is ignored during the wait and the whole sequence. After returning to ready, the block stays ready until a new `wait_set` pulse.
- R9: Qualifying requests from wait entry until ready are held. They appear on `irq_out` in the first ready cycle, together with any live requests. `irq_out` is 0 whenever `cpu_ready` is 0.
- R10: After reset, `cpu_ready`, `cpu_clk_en` and `flash_en` are 1. `lp_mode`, `clk_sel` and `irq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_set | input | 1 | Software write of 1 to the wait-request bit |
| irq_req | input | N_IRQ | Peripheral interrupt requests |
| irq_lvl | input | 3*N_IRQ | Priority level per request, 3 bits each, request i at bits 3i+2:3i |
| lowpwr_cfg | input | 1 | Low-consumption internal power during wait |
| flash_stop_cfg | input | 1 | Flash shut down during wait |
| clk_src_cfg | input | 3 | Clock source to use after wake |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| clk_sel | output | 3 | Current CPU clock select |
| osc_lo_sel | output | 1 | Low-speed oscillator selected (clk_sel bit 2) |
| div_sel | output | 2 | Divider code (clk_sel bits 1:0) |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| flash_en | output | 1 | Flash powered |
| lp_mode | output | 1 | Internal power in low-consumption state |
| cpu_ready | output | 1 | CPU may fetch |
| irq_out | output | N_IRQ | Requests presented to the CPU |

## Verification
Entering wait is visible one edge after the `wait_set` pulse, so the bench checks the captured state at the next falling edge. Phase lengths cannot be checked at a fixed offset, because they depend on when ticks arrive. So from the wake edge on, the bench sorts each cycle at the falling edge by the gating outputs. It counts the ticks it drives in power and flash cycles and the cycles of running clock before ready, then compares those counts with the expected tick and cycle numbers. The held requests and the new clock select are checked in the first ready cycle, and the cleared `irq_out` one cycle later.

// File: rtl/wake_seq.sv
module wake_seq #(
  parameter int N_IRQ    = 4,
  parameter int PWR_US   = 100,
  parameter int FLASH_US = 60,
  parameter int CLK_CYC  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wait_set,
  input  logic [N_IRQ-1:0]   irq_req,
  input  logic [3*N_IRQ-1:0] irq_lvl,
  input  logic               lowpwr_cfg,
  input  logic               flash_stop_cfg,
  input  logic [2:0]         clk_src_cfg,
  input  logic               us_tick,
  output logic [2:0]         clk_sel,
  output logic               osc_lo_sel,
  output logic [1:0]         div_sel,
  output logic               cpu_clk_en,
  output logic               flash_en,
  output logic               lp_mode,
  output logic               cpu_ready,
  output logic [N_IRQ-1:0]   irq_out
);
  localparam int MAXC = (PWR_US > FLASH_US) ? PWR_US : FLASH_US;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_RUN = 3'd0, S_WAIT = 3'd1, S_PWR = 3'd2,
    S_FLS = 3'd3, S_FLW = 3'd4, S_CLK = 3'd5
  } st_t;

  st_t st;
  logic [CW-1:0]    cnt;
  logic             lp_cap, fo_cap;
  logic [2:0]       sel_cap, cur_sel;
  logic [N_IRQ-1:0] pend, elig;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_elig
    assign elig[i] = irq_req[i] & (|irq_lvl[3*i +: 3]);
  end

  wire wake = |elig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RUN;
      cnt     <= '0;
      lp_cap  <= 1'b0;
      fo_cap  <= 1'b0;
      sel_cap <= '0;
      cur_sel <= '0;
      pend    <= '0;
    end else begin
      pend <= (st == S_RUN) ? '0 : (pend | elig);
      case (st)
        S_RUN: if (wait_set) begin
          st      <= S_WAIT;
          lp_cap  <= lowpwr_cfg;
          fo_cap  <= flash_stop_cfg;
          sel_cap <= clk_src_cfg;
        end
        S_WAIT: if (wake) begin
          st  <= lp_cap ? S_PWR : S_FLS;
          cnt <= '0;
        end
        S_PWR: if (us_tick) begin
          if (cnt == CW'(PWR_US - 1)) begin
            st  <= S_FLS;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_FLS: begin
          cnt <= '0;
          if (fo_cap) st <= S_FLW;
          else begin
            st      <= S_CLK;
            cur_sel <= sel_cap;
          end
        end
        S_FLW: if (us_tick) begin
          if (cnt == CW'(FLASH_US - 1)) begin
            st      <= S_CLK;
            cur_sel <= sel_cap;
            cnt     <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_CLK: begin
          if (cnt == CW'(CLK_CYC - 1)) begin
            st  <= S_RUN;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign cpu_ready  = (st == S_RUN);
  assign cpu_clk_en = (st == S_RUN) || (st == S_CLK);
  assign lp_mode    = lp_cap && ((st == S_WAIT) || (st == S_PWR));
  assign flash_en   = !(fo_cap && (st inside {S_WAIT, S_PWR, S_FLS, S_FLW}));
  assign clk_sel    = cur_sel;
  assign osc_lo_sel = cur_sel[2];
  assign div_sel    = cur_sel[1:0];
  assign irq_out    = cpu_ready ? (pend | elig) : '0;
endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk #(
  parameter int N_IRQ = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         st,
  input logic               wait_set,
  input logic [N_IRQ-1:0]   irq_req,
  input logic [3*N_IRQ-1:0] irq_lvl,
  input logic               cpu_ready,
  input logic               cpu_clk_en,
  input logic               flash_en,
  input logic               lp_mode,
  input logic [2:0]         clk_sel,
  input logic [N_IRQ-1:0]   irq_out
);
  logic nz_any;
  always_comb begin
    nz_any = 1'b0;
    for (int i = 0; i < N_IRQ; i++)
      if (irq_req[i] && irq_lvl[3*i +: 3] != 3'b000) nz_any = 1'b1;
  end

  assert_zero_level_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && !nz_any) |=> (st == 3'd1));
  assert_level_wakes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && nz_any) |=> (st != 3'd1));
  assert_enter_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && wait_set) |=> (!cpu_ready && !cpu_clk_en));
  assert_flash_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> (flash_en && !lp_mode));
  assert_clk_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_ready) |-> ($past(cpu_clk_en) && $past(cpu_clk_en, 2)));
  assert_pwr_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2) |=> (st == 3'd2 || st == 3'd3));
  assert_flash_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 || st == 3'd4) |=> (st == 3'd4 || st == 3'd5));
  assert_sel_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && $past(cpu_ready)) |-> $stable(clk_sel));
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> (irq_out == '0));
endmodule

bind wake_seq wake_seq_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .wait_set(wait_set),
  .irq_req(irq_req), .irq_lvl(irq_lvl), .cpu_ready(cpu_ready),
  .cpu_clk_en(cpu_clk_en), .flash_en(flash_en), .lp_mode(lp_mode),
  .clk_sel(clk_sel), .irq_out(irq_out)
);

// File: tb/tb_wake_seq.sv
module tb_wake_seq;
  localparam int N = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n, wait_set, lowpwr_cfg, flash_stop_cfg, us_tick;
  logic [N-1:0]   irq_req;
  logic [3*N-1:0] irq_lvl;
  logic [2:0]     clk_src_cfg, clk_sel;
  logic           osc_lo_sel, cpu_clk_en, flash_en, lp_mode, cpu_ready;
  logic [1:0]     div_sel;
  logic [N-1:0]   irq_out;

  wake_seq #(.N_IRQ(N)) dut (
    .clk(clk), .rst_n(rst_n), .wait_set(wait_set), .irq_req(irq_req),
    .irq_lvl(irq_lvl), .lowpwr_cfg(lowpwr_cfg), .flash_stop_cfg(flash_stop_cfg),
    .clk_src_cfg(clk_src_cfg), .us_tick(us_tick), .clk_sel(clk_sel),
    .osc_lo_sel(osc_lo_sel), .div_sel(div_sel), .cpu_clk_en(cpu_clk_en),
    .flash_en(flash_en), .lp_mode(lp_mode), .cpu_ready(cpu_ready), .irq_out(irq_out)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pwr_ticks(bit lp);   return lp ? 100 : 0; endfunction
  function automatic int exp_flash_ticks(bit fo); return fo ? 60 : 0; endfunction
  function automatic int exp_clk_cycles();        return 2; endfunction

  task automatic run_case(input bit lp, input bit fo, input logic [2:0] sel, input int widx);
    logic [2:0]   prev_sel;
    logic [N-1:0] exp_pend;
    int pt, ft, fc, cc, last, phase;
    bit order_bad, tk, done;
    pt = 0; ft = 0; fc = 0; cc = 0; last = 0; order_bad = 0; done = 0;
    @(negedge clk);
    prev_sel = clk_sel;
    wait_set = 1'b1; lowpwr_cfg = lp; flash_stop_cfg = fo; clk_src_cfg = sel;
    @(negedge clk);
    wait_set = 1'b0; lowpwr_cfg = ~lp; flash_stop_cfg = ~fo; clk_src_cfg = ~sel;
    chk(!cpu_ready && !cpu_clk_en, "R2 wait entry", int'(cpu_ready), 0);
    chk(lp_mode == lp, "R3 lp_mode in wait", int'(lp_mode), int'(lp));
    chk(flash_en == !fo, "R4 flash_en in wait", int'(flash_en), int'(!fo));
    chk(clk_sel == prev_sel, "R7 clk_sel held in wait", int'(clk_sel), int'(prev_sel));
    irq_lvl[3*widx +: 3] = 3'b000;
    irq_req[widx] = 1'b1;
    for (int k = 0; k < 8; k++) begin
      wait_set = k[0];
      us_tick = ($urandom % 3 == 0);
      @(negedge clk);
    end
    wait_set = 1'b0;
    chk(!cpu_ready && !cpu_clk_en, "R1 zero level no wake", int'(cpu_ready), 0);
    chk(!cpu_ready, "R8 wait_set ignored in wait", int'(cpu_ready), 0);
    irq_lvl[3*widx +: 3] = 3'(1 + $urandom % 7);
    exp_pend = '0;
    exp_pend[widx] = 1'b1;
    us_tick = 1'b0;
    @(negedge clk);
    irq_req = '0;
    for (int n = 0; n < 5000 && !done; n++) begin
      if (cpu_ready) begin
        done = 1;
      end else begin
        phase = cpu_clk_en ? 3 : (lp_mode ? 1 : 2);
        if (phase < last) order_bad = 1;
        last = phase;
        tk = ($urandom % 3 == 0);
        case (phase)
          1: if (tk) pt++;
          2: begin fc++; if (fc > 1 && tk) ft++; end
          default: cc++;
        endcase
        us_tick = tk;
        irq_req = '0;
        if ($urandom % 16 == 0) begin
          int j;
          j = $urandom % N;
          irq_lvl[3*j +: 3] = 3'(1 + $urandom % 7);
          irq_req[j] = 1'b1;
          exp_pend[j] = 1'b1;
        end
        wait_set = ($urandom % 5 == 0);
        @(negedge clk);
      end
    end
    irq_req = '0; wait_set = 1'b0; us_tick = 1'b0;
    #1;
    chk(done, "R6 sequence completed", int'(done), 1);
    chk(pt == exp_pwr_ticks(lp), "R3 power phase ticks", pt, exp_pwr_ticks(lp));
    if (fo) chk(ft == exp_flash_ticks(fo), "R4 flash phase ticks", ft, exp_flash_ticks(fo));
    else    chk(fc == 1, "R4 flash phase cycles", fc, 1);
    chk(cc == exp_clk_cycles(), "R5 clock restart cycles", cc, exp_clk_cycles());
    chk(!order_bad, "R6 phase order", int'(order_bad), 0);
    chk(clk_sel == sel, "R7 clk_sel after wake", int'(clk_sel), int'(sel));
    chk(osc_lo_sel == sel[2], "R7 osc_lo_sel", int'(osc_lo_sel), int'(sel[2]));
    chk(div_sel == sel[1:0], "R7 div_sel", int'(div_sel), int'(sel[1:0]));
    chk(irq_out == exp_pend, "R9 held requests", int'(irq_out), int'(exp_pend));
    @(negedge clk);
    chk(irq_out == '0, "R9 held cleared", int'(irq_out), 0);
    repeat (5) @(negedge clk);
    chk(cpu_ready && cpu_clk_en, "R8 stays ready", int'(cpu_ready), 1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; wait_set = 1'b0; lowpwr_cfg = 1'b0; flash_stop_cfg = 1'b0;
    us_tick = 1'b0; irq_req = '0; irq_lvl = '0; clk_src_cfg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_ready && cpu_clk_en && flash_en, "R10 reset enables", int'(cpu_ready), 1);
    chk(!lp_mode && clk_sel == 3'd0 && irq_out == '0, "R10 reset zeros", int'(clk_sel), 0);
    run_case(1'b0, 1'b0, 3'd5, 0);
    run_case(1'b1, 1'b0, 3'd2, 1);
    run_case(1'b0, 1'b1, 3'd7, 2);
    run_case(1'b1, 1'b1, 3'd1, 3);
    for (int r = 0; r < 8; r++)
      run_case(1'($urandom), 1'($urandom), 3'($urandom), int'($urandom % N));
    summary();
    $finish;
  end
endmodule